// File: doc/BRIEF.md
# External-Control Access Splitter

This block sits between a requester of external-control reads and writes and a shared address bus. Every request moves exactly four bytes, named by a byte address, a direction and a 4-bit resource ID. When the four bytes fall inside one aligned 8-byte block, the splitter issues a single 4-byte bus operation. When they spill past the end of that block (low address bits 5, 6 or 7), it issues a shorter first operation at the request address and a second one at the start of the next block, and the two lengths add up to four.

On every operation the burst pin and the 3-bit size field are not used for their usual purpose. They carry the resource ID instead: the burst pin shows the ID's top bit as is, and the size field shows the lower three bits. The real byte count travels on a separate length output for the data path. The two halves of a split are not atomic. Other bus traffic, and a request of the opposite direction, may be issued between them, but a second request of the same direction waits until the split has finished. A transfer error reported on the first half cancels the second half and is passed back to the requester.

A parameter chooses whether a waiting second half yields to other traffic (the default) or goes first as soon as the bus is free.

Top module: `xctl_splitter`

## Requirements
- R1: A request whose address low three bits are 0 to 4 produces exactly one operation with bus_addr equal to req_addr and bus_len equal to 4 (bus_len is the byte count in binary).
- R2: A request whose address low three bits are 5, 6 or 7 produces a first operation at bus_addr equal to req_addr with bus_len 3, 2 or 1 respectively, never running past the end of its 8-byte block.
- R3: The second operation of a split has bus_addr equal to req_addr with its low three bits cleared plus 8 (modulo 2^32) and bus_len 1, 2 or 3, so the two lengths sum to 4.
- R4: On every operation of a request, bus_burst equals resource-ID bit 3, bus_szf equals resource-ID bits 2:0, and bus_write equals req_write (1 means write).
- R5: bus_valid rises the cycle after the operation is granted, holds with all bus fields stable until the edge where bus_ack is sampled high, and is low in the cycle after that edge.
- R6: While a split of one direction has its second half outstanding, a request of the same direction is not accepted (req_ready stays low), and it is accepted once the split has completed.
- R7: With the default setting, a request of the opposite direction presented while a second half is waiting is accepted first and its operation is issued before that second half.
- R8: When the bus is free and oth_req is high, oth_gnt is asserted in that cycle and req_ready is low; no operation of this block is driven until bus_ack ends the granted tenure.
- R9: If bus_err is high with bus_ack on the first half of a split, the second half is never issued and a request of the same direction is accepted on the next free cycle.
- R10: rsp_valid is high for one cycle, in the cycle after the bus_ack that ends the last operation of a request (or the first half on error); rsp_write gives the direction and rsp_err the bus_err sampled with that bus_ack.
- R11: After reset bus_valid, rsp_valid and oth_gnt are low and the block is free to accept a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge |
| req_addr | input | 32 | Byte address of the 4-byte access |
| req_write | input | 1 | 1 write, 0 read |
| req_rid | input | 4 | Resource ID |
| oth_req | input | 1 | Other bus traffic wants the bus |
| oth_gnt | output | 1 | Bus handed to other traffic for one tenure |
| bus_valid | output | 1 | Operation driven, held until bus_ack |
| bus_addr | output | 32 | Operation byte address |
| bus_write | output | 1 | Operation direction |
| bus_burst | output | 1 | Resource-ID bit 3 |
| bus_szf | output | 3 | Resource-ID bits 2:0 |
| bus_len | output | 3 | Byte count of the operation |
| bus_ack | input | 1 | Ends the current tenure |
| bus_err | input | 1 | Transfer error, sampled with bus_ack |
| rsp_valid | output | 1 | Request completed |
| rsp_write | output | 1 | Direction of the completed request |
| rsp_err | output | 1 | Completed with a transfer error |

## Verification
req_ready and oth_gnt are combinational and are due in the same cycle as the inputs that raise them; an operation appears on bus_valid one edge after its grant, and rsp_valid one edge after the final bus_ack. A second half is granted in the free cycle after its first half's bus_ack and appears one edge later. The bench changes inputs on the falling edge and reads outputs on the next falling edge, counting exactly these edges, so each check samples the cycle in which the result is due, and it also checks that fields held across an extra un-acknowledged cycle do not move.

// File: rtl/xcs_pkg.sv
package xcs_pkg;

   typedef enum logic [1:0] {
      SL_IDLE  = 2'd0,
      SL_WAIT  = 2'd1,
      SL_READY = 2'd2,
      SL_BUSY  = 2'd3
   } slot_st_t;

   typedef enum logic [1:0] {
      TK_ONLY   = 2'd0,
      TK_FIRST  = 2'd1,
      TK_SECOND = 2'd2,
      TK_OTHER  = 2'd3
   } tenure_t;

endpackage

// File: rtl/xcs_planner.sv
module xcs_planner #(
   parameter int AW        = 32,
   parameter int BLK_BYTES = 8,
   parameter int ACC_BYTES = 4,
   localparam int OFFW     = $clog2(BLK_BYTES),
   localparam int LENW     = $clog2(ACC_BYTES + 1)
) (
   input  logic [AW-1:0]   addr,
   output logic            split,
   output logic [LENW-1:0] first_len,
   output logic [LENW-1:0] sec_len,
   output logic [AW-1:0]   sec_addr
);

   localparam logic [OFFW:0]   BLK_W = (OFFW+1)'(BLK_BYTES);
   localparam logic [OFFW:0]   ACC_W = (OFFW+1)'(ACC_BYTES);
   localparam logic [LENW-1:0] ACC_L = LENW'(ACC_BYTES);

   logic [OFFW:0] room;

   assign room     = BLK_W - {1'b0, addr[OFFW-1:0]};
   assign sec_addr = {addr[AW-1:OFFW] + (AW-OFFW)'(1), {OFFW{1'b0}}};

   generate
      if (ACC_BYTES == BLK_BYTES) begin : g_never_split
         assign split     = 1'b0;
         assign first_len = ACC_L;
      end else begin : g_may_split
         assign split     = room < ACC_W;
         assign first_len = split ? room[LENW-1:0] : ACC_L;
      end
   endgenerate

   assign sec_len = ACC_L - first_len;

endmodule

// File: rtl/xcs_half_slot.sv
module xcs_half_slot import xcs_pkg::*; #(
   parameter int AW   = 32,
   parameter int LENW = 3,
   parameter int RIDW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [AW-1:0]   ld_addr,
   input  logic [LENW-1:0] ld_len,
   input  logic [RIDW-1:0] ld_rid,
   input  logic            arm,
   input  logic            drop,
   input  logic            take,
   output logic            pending,
   output logic            ready,
   output logic [AW-1:0]   addr,
   output logic [LENW-1:0] len,
   output logic [RIDW-1:0] rid
);

   slot_st_t st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= SL_IDLE;
         addr <= '0;
         len  <= '0;
         rid  <= '0;
      end else if (drop) begin
         st_q <= SL_IDLE;
      end else if (load) begin
         st_q <= SL_WAIT;
         addr <= ld_addr;
         len  <= ld_len;
         rid  <= ld_rid;
      end else if (arm && st_q == SL_WAIT) begin
         st_q <= SL_READY;
      end else if (take && st_q == SL_READY) begin
         st_q <= SL_BUSY;
      end
   end

   assign pending = (st_q != SL_IDLE);
   assign ready   = (st_q == SL_READY);

endmodule

// File: rtl/xcs_arbiter.sv
module xcs_arbiter #(
   parameter bit ALLOW_OVERTAKE = 1'b1
) (
   input  logic       idle,
   input  logic       oth_req,
   input  logic       new_req,
   input  logic [1:0] sec_rdy,
   output logic       gnt_oth,
   output logic       gnt_new,
   output logic [1:0] gnt_sec
);

   logic [1:0] sec_pick;

   assign sec_pick = sec_rdy[1] ? 2'b10 : {1'b0, sec_rdy[0]};

   generate
      if (ALLOW_OVERTAKE) begin : g_yield
         assign gnt_oth = idle && oth_req;
         assign gnt_new = idle && !oth_req && new_req;
         assign gnt_sec = (idle && !oth_req && !new_req) ? sec_pick : 2'b00;
      end else begin : g_finish_first
         logic has_sec;
         assign has_sec = |sec_rdy;
         assign gnt_sec = idle ? sec_pick : 2'b00;
         assign gnt_oth = idle && !has_sec && oth_req;
         assign gnt_new = idle && !has_sec && !oth_req && new_req;
      end
   endgenerate

endmodule

// File: rtl/xctl_splitter.sv
module xctl_splitter import xcs_pkg::*; #(
   parameter int  AW             = 32,
   parameter int  BLK_BYTES      = 8,
   parameter int  ACC_BYTES      = 4,
   parameter int  RIDW           = 4,
   parameter bit  ALLOW_OVERTAKE = 1'b1,
   localparam int LENW           = $clog2(ACC_BYTES + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [AW-1:0]   req_addr,
   input  logic            req_write,
   input  logic [RIDW-1:0] req_rid,
   input  logic            oth_req,
   output logic            oth_gnt,
   output logic            bus_valid,
   output logic [AW-1:0]   bus_addr,
   output logic            bus_write,
   output logic            bus_burst,
   output logic [RIDW-2:0] bus_szf,
   output logic [LENW-1:0] bus_len,
   input  logic            bus_ack,
   input  logic            bus_err,
   output logic            rsp_valid,
   output logic            rsp_write,
   output logic            rsp_err
);

   // elaboration-time parameter checks
   generate
      if (ACC_BYTES > BLK_BYTES) begin : g_bad_acc
         $error("ACC_BYTES must not exceed BLK_BYTES");
      end
      if ((BLK_BYTES & (BLK_BYTES - 1)) != 0 || BLK_BYTES < 2) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two of at least 2");
      end
      if (RIDW < 2) begin : g_bad_rid
         $error("RIDW must be at least 2");
      end
      if (AW <= $clog2(BLK_BYTES)) begin : g_bad_aw
         $error("AW must exceed the block offset width");
      end
   endgenerate

   logic    busy_q;
   tenure_t kind_q;
   logic    dir_q;
   logic    done;
   logic    new_req;
   logic    gnt_new;
   logic    sec_dir;
   logic [1:0] gnt_sec;

   logic            pl_split;
   logic [LENW-1:0] pl_first_len;
   logic [LENW-1:0] pl_sec_len;
   logic [AW-1:0]   pl_sec_addr;

   logic [1:0]      sl_pend, sl_rdy, sl_load, sl_arm, sl_drop;
   logic [AW-1:0]   sl_addr [2];
   logic [LENW-1:0] sl_len  [2];
   logic [RIDW-1:0] sl_rid  [2];

   xcs_planner #(
      .AW(AW), .BLK_BYTES(BLK_BYTES), .ACC_BYTES(ACC_BYTES)
   ) planner_i (
      .addr      (req_addr),
      .split     (pl_split),
      .first_len (pl_first_len),
      .sec_len   (pl_sec_len),
      .sec_addr  (pl_sec_addr)
   );

   assign done    = busy_q && bus_ack;
   assign new_req = req_valid && !sl_pend[req_write];

   // one second-half slot per direction: index 1 write, 0 read
   generate
      for (genvar d = 0; d < 2; d++) begin : g_slot
         assign sl_load[d] = gnt_new && pl_split && (req_write == 1'(d));
         assign sl_arm[d]  = done && kind_q == TK_FIRST && dir_q == 1'(d) && !bus_err;
         assign sl_drop[d] = done && dir_q == 1'(d) &&
                             ((kind_q == TK_FIRST && bus_err) || kind_q == TK_SECOND);

         xcs_half_slot #(
            .AW(AW), .LENW(LENW), .RIDW(RIDW)
         ) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (sl_load[d]),
            .ld_addr (pl_sec_addr),
            .ld_len  (pl_sec_len),
            .ld_rid  (req_rid),
            .arm     (sl_arm[d]),
            .drop    (sl_drop[d]),
            .take    (gnt_sec[d]),
            .pending (sl_pend[d]),
            .ready   (sl_rdy[d]),
            .addr    (sl_addr[d]),
            .len     (sl_len[d]),
            .rid     (sl_rid[d])
         );
      end
   endgenerate

   xcs_arbiter #(
      .ALLOW_OVERTAKE(ALLOW_OVERTAKE)
   ) arb_i (
      .idle    (!busy_q),
      .oth_req (oth_req),
      .new_req (new_req),
      .sec_rdy (sl_rdy),
      .gnt_oth (oth_gnt),
      .gnt_new (gnt_new),
      .gnt_sec (gnt_sec)
   );

   assign req_ready = gnt_new;
   assign sec_dir   = gnt_sec[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         kind_q    <= TK_ONLY;
         dir_q     <= 1'b0;
         bus_valid <= 1'b0;
         bus_addr  <= '0;
         bus_write <= 1'b0;
         bus_burst <= 1'b0;
         bus_szf   <= '0;
         bus_len   <= '0;
         rsp_valid <= 1'b0;
         rsp_write <= 1'b0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         if (done) begin
            busy_q    <= 1'b0;
            bus_valid <= 1'b0;
            if (kind_q == TK_ONLY || kind_q == TK_SECOND ||
                (kind_q == TK_FIRST && bus_err)) begin
               rsp_valid <= 1'b1;
               rsp_write <= dir_q;
               rsp_err   <= bus_err;
            end
         end else if (!busy_q) begin
            if (oth_gnt) begin
               busy_q <= 1'b1;
               kind_q <= TK_OTHER;
            end else if (gnt_new) begin
               busy_q    <= 1'b1;
               kind_q    <= pl_split ? TK_FIRST : TK_ONLY;
               dir_q     <= req_write;
               bus_valid <= 1'b1;
               bus_addr  <= req_addr;
               bus_len   <= pl_first_len;
               bus_write <= req_write;
               bus_burst <= req_rid[RIDW-1];
               bus_szf   <= req_rid[RIDW-2:0];
            end else if (|gnt_sec) begin
               busy_q    <= 1'b1;
               kind_q    <= TK_SECOND;
               dir_q     <= sec_dir;
               bus_valid <= 1'b1;
               bus_addr  <= sl_addr[sec_dir];
               bus_len   <= sl_len[sec_dir];
               bus_write <= sec_dir;
               bus_burst <= sl_rid[sec_dir][RIDW-1];
               bus_szf   <= sl_rid[sec_dir][RIDW-2:0];
            end
         end
      end
   end

endmodule

// File: rtl/xctl_splitter_chk.sv
module xctl_splitter_chk #(
   parameter int  AW        = 32,
   parameter int  BLK_BYTES = 8,
   parameter int  ACC_BYTES = 4,
   parameter int  RIDW      = 4,
   localparam int OFFW      = $clog2(BLK_BYTES),
   localparam int LENW      = $clog2(ACC_BYTES + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            oth_gnt,
   input logic            bus_valid,
   input logic [AW-1:0]   bus_addr,
   input logic            bus_write,
   input logic            bus_burst,
   input logic [RIDW-2:0] bus_szf,
   input logic [LENW-1:0] bus_len,
   input logic            bus_ack,
   input logic            rsp_valid
);

   logic [OFFW:0] end_pos;
   assign end_pos = {1'b0, bus_addr[OFFW-1:0]} + (OFFW+1)'(bus_len);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_len) &&
                                $stable(bus_write) && $stable(bus_burst) && $stable(bus_szf));

   assert_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ack |=> !bus_valid);

   assert_in_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> end_pos <= (OFFW+1)'(BLK_BYTES));

   assert_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> bus_len != '0 && bus_len <= LENW'(ACC_BYTES));

   assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_oth_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      oth_gnt |-> !bus_valid && !req_ready);

endmodule

bind xctl_splitter xctl_splitter_chk #(
   .AW(AW), .BLK_BYTES(BLK_BYTES), .ACC_BYTES(ACC_BYTES), .RIDW(RIDW)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .oth_gnt   (oth_gnt),
   .bus_valid (bus_valid),
   .bus_addr  (bus_addr),
   .bus_write (bus_write),
   .bus_burst (bus_burst),
   .bus_szf   (bus_szf),
   .bus_len   (bus_len),
   .bus_ack   (bus_ack),
   .rsp_valid (rsp_valid)
);

// File: tb/xctl_splitter_tb_top.sv
`timescale 1ns/1ps
module xctl_splitter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [3:0]  req_rid = '0;
   logic        oth_req = 1'b0;
   logic        oth_gnt;
   logic        bus_valid;
   logic [31:0] bus_addr;
   logic        bus_write;
   logic        bus_burst;
   logic [2:0]  bus_szf;
   logic [2:0]  bus_len;
   logic        bus_ack = 1'b0;
   logic        bus_err = 1'b0;
   logic        rsp_valid;
   logic        rsp_write;
   logic        rsp_err;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   xctl_splitter dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_rid(req_rid),
      .oth_req(oth_req), .oth_gnt(oth_gnt),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
      .bus_burst(bus_burst), .bus_szf(bus_szf), .bus_len(bus_len),
      .bus_ack(bus_ack), .bus_err(bus_err),
      .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_err(rsp_err)
   );

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] next_blk(input logic [31:0] a);
      return (a & ~32'h7) + 32'd8;
   endfunction

   // present a request and wait until it is taken; returns at the falling edge after acceptance
   task automatic send_req(input logic [31:0] a, input logic wr, input logic [3:0] rid);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_rid = rid;
      for (int w = 0; w < 40 && !req_ready; w++) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // wait for one operation, check it, hold one cycle, acknowledge it
   task automatic expect_op(input logic [31:0] a, input logic [2:0] len, input logic wr,
                            input logic [3:0] rid, input logic err, input logic last,
                            input string rq);
      logic [31:0] a_seen;
      for (int w = 0; w < 40 && !bus_valid; w++) @(negedge clk);
      chk(rq, "bus_valid", 32'(bus_valid), 32'd1);
      chk(rq, "bus_addr", bus_addr, a);
      chk(rq, "bus_len", 32'(bus_len), 32'(len));
      chk("R4", "bus_write", 32'(bus_write), 32'(wr));
      chk("R4", "bus_burst", 32'(bus_burst), 32'(rid[3]));
      chk("R4", "bus_szf", 32'(bus_szf), 32'(rid[2:0]));
      a_seen = bus_addr;
      @(negedge clk);
      chk("R5", "held addr", bus_addr, a_seen);
      chk("R5", "held valid", 32'(bus_valid), 32'd1);
      bus_ack = 1'b1; bus_err = err;
      @(negedge clk);
      bus_ack = 1'b0; bus_err = 1'b0;
      chk("R5", "valid after ack", 32'(bus_valid), 32'd0);
      chk("R10", "rsp_valid", 32'(rsp_valid), 32'(last));
      if (last) begin
         chk("R10", "rsp_err", 32'(rsp_err), 32'(err));
         chk("R10", "rsp_write", 32'(rsp_write), 32'(wr));
      end
   endtask

   task automatic t_reset();
      chk("R11", "bus_valid", 32'(bus_valid), 32'd0);
      chk("R11", "rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R11", "oth_gnt", 32'(oth_gnt), 32'd0);
      req_valid = 1'b1; req_addr = 32'h100; req_write = 1'b0; req_rid = 4'h0;
      #0.5;
      chk("R11", "ready when free", 32'(req_ready), 32'd1);
      req_valid = 1'b0;
   endtask

   task automatic t_aligned(input logic [31:0] a, input logic wr, input logic [3:0] rid);
      send_req(a, wr, rid);
      expect_op(a, 3'd4, wr, rid, 1'b0, 1'b1, "R1");
   endtask

   task automatic t_split(input logic [31:0] a, input logic wr, input logic [3:0] rid);
      int off = int'(a[2:0]);
      send_req(a, wr, rid);
      expect_op(a, 3'(8 - off), wr, rid, 1'b0, 1'b0, "R2");
      expect_op(next_blk(a), 3'(off - 4), wr, rid, 1'b0, 1'b1, "R3");
   endtask

   task automatic t_block();
      send_req(32'h3000_0006, 1'b1, 4'h5);
      req_valid = 1'b1; req_addr = 32'h3000_0010; req_write = 1'b1; req_rid = 4'h1;
      expect_op(32'h3000_0006, 3'd2, 1'b1, 4'h5, 1'b0, 1'b0, "R6");
      chk("R6", "same dir blocked", 32'(req_ready), 32'd0);
      expect_op(32'h3000_0008, 3'd2, 1'b1, 4'h5, 1'b0, 1'b1, "R6");
      chk("R6", "accepted after split", 32'(req_ready), 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      expect_op(32'h3000_0010, 3'd4, 1'b1, 4'h1, 1'b0, 1'b1, "R6");
   endtask

   task automatic t_overtake();
      send_req(32'h1000_0105, 1'b0, 4'hA);
      req_valid = 1'b1; req_addr = 32'h2000_0000; req_write = 1'b1; req_rid = 4'h3;
      expect_op(32'h1000_0105, 3'd3, 1'b0, 4'hA, 1'b0, 1'b0, "R7");
      chk("R7", "opposite dir ready", 32'(req_ready), 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      expect_op(32'h2000_0000, 3'd4, 1'b1, 4'h3, 1'b0, 1'b1, "R7");
      expect_op(32'h1000_0108, 3'd1, 1'b0, 4'hA, 1'b0, 1'b1, "R7");
   endtask

   task automatic t_other();
      send_req(32'h0000_4007, 1'b0, 4'h9);
      oth_req = 1'b1;
      expect_op(32'h0000_4007, 3'd1, 1'b0, 4'h9, 1'b0, 1'b0, "R8");
      chk("R8", "oth_gnt", 32'(oth_gnt), 32'd1);
      @(negedge clk);
      oth_req = 1'b0;
      chk("R8", "no op in other tenure", 32'(bus_valid), 32'd0);
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
      expect_op(32'h0000_4008, 3'd3, 1'b0, 4'h9, 1'b0, 1'b1, "R8");
   endtask

   task automatic t_err_first();
      send_req(32'h5000_0005, 1'b1, 4'hF);
      expect_op(32'h5000_0005, 3'd3, 1'b1, 4'hF, 1'b1, 1'b1, "R9");
      repeat (3) @(negedge clk);
      chk("R9", "second half dropped", 32'(bus_valid), 32'd0);
      req_valid = 1'b1; req_addr = 32'h5000_0040; req_write = 1'b1; req_rid = 4'h2;
      #0.5;
      chk("R9", "same dir free", 32'(req_ready), 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      expect_op(32'h5000_0040, 3'd4, 1'b1, 4'h2, 1'b0, 1'b1, "R9");
   endtask

   task automatic t_err_only();
      send_req(32'h6000_0050, 1'b0, 4'h6);
      expect_op(32'h6000_0050, 3'd4, 1'b0, 4'h6, 1'b1, 1'b1, "R10");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R5 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_aligned(32'h0000_1000, 1'b0, 4'h0);
      t_aligned(32'h0000_2003, 1'b1, 4'hC);
      t_aligned(32'h0000_3004, 1'b0, 4'h7);
      t_split(32'h8000_0015, 1'b0, 4'h8);
      t_split(32'h8000_0026, 1'b1, 4'h3);
      t_split(32'h8000_0037, 1'b0, 4'hE);
      t_split(32'hFFFF_FFFE, 1'b1, 4'h1);
      t_block();
      t_overtake();
      t_other();
      t_err_first();
      t_err_only();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule